// File: doc/BRIEF.md
# Crypto Instruction Macro Recorder

This block holds one short macro of crypto instructions. A begin command opens a recording; every instruction command that follows (a 5-bit opcode with a 4-bit and a 6-bit operand) is written into a small local instruction store until an end command closes the macro. An execute command then plays the stored instructions back, oldest first, on an issue port that advances one entry per valid/ready handshake. The closed macro stays in the store, so it can be executed again without being recorded a second time.

Three sticky error flags report misuse: closing an empty macro, recording more instructions than the store holds, and asking for execution while a recording is still open. The block also exposes live debug state: the mode, the macro size, the current store address, the number of instructions still to issue and an activity flag. A synchronous clear input flushes everything back to idle. The crypto datapath that consumes the issued instructions is outside this block.

Top module: `cseq_recorder`

## Requirements
- R1: After reset, and one cycle after clear_i is high, state_o is 0 (idle), size_o, addr_o and left_o are 0, all three error flags are 0, and iss_valid_o and active_o are 0.
- R2: A begin command (cmd_kind_i = 1) accepted in idle, or while recording, sets state_o to 1 (recording) with size_o and addr_o at 0.
- R3: While recording, an instruction command (cmd_kind_i = 0) stores {opcode, first operand, second operand} at the next free slot, and size_o and addr_o each advance by one.
- R4: An instruction command arriving while the store already holds DEPTH (16) entries is discarded, leaves size_o at 16, and sets err_long_o.
- R5: An end command (cmd_kind_i = 2) while recording returns state_o to 0 with addr_o at 0; if size_o was 0 it also sets err_empty_o.
- R6: An execute command (cmd_kind_i = 3) while recording sets err_open_o and leaves the block recording with its size unchanged.
- R7: An execute command in idle with a non-zero size sets state_o to 2 (replaying), addr_o to 0 and left_o to size_o minus 1, and raises iss_valid_o with the first stored instruction.
- R8: During replay the issued instruction, addr_o and left_o hold while iss_ready_i is low; each cycle with iss_ready_i high advances addr_o and lowers left_o by one, and the accept made with left_o at 0 returns the block to idle with the macro kept for later execution.
- R9: Each error flag stays set through any later command until clear_i is asserted.
- R10: Instruction and end commands in idle, an execute command in idle with size 0, and every command during replay change neither state_o, size_o, addr_o nor left_o.
- R11: active_o is high exactly while state_o is recording or replaying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a local synchronizer |
| clear_i | input | 1 | Synchronous flush to idle; clears size and errors |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_kind_i | input | 2 | 0 instruction, 1 begin, 2 end, 3 execute |
| cmd_opc_i | input | 5 | Instruction opcode |
| cmd_opa_i | input | 4 | Instruction first operand |
| cmd_opb_i | input | 6 | Instruction second operand |
| iss_ready_i | input | 1 | Consumer accepts the issued instruction |
| iss_valid_o | output | 1 | Issued instruction is meaningful (replaying) |
| iss_opc_o | output | 5 | Issued opcode |
| iss_opa_o | output | 4 | Issued first operand |
| iss_opb_o | output | 6 | Issued second operand |
| state_o | output | 2 | 0 idle, 1 recording, 2 replaying |
| size_o | output | 5 | Number of stored instructions |
| addr_o | output | 4 | Next write slot when recording, read slot when replaying |
| left_o | output | 4 | Instructions still to issue after the current one |
| active_o | output | 1 | Recording or replaying |
| err_empty_o | output | 1 | Sticky: empty macro closed |
| err_long_o | output | 1 | Sticky: store capacity exceeded |
| err_open_o | output | 1 | Sticky: execute while recording |

## Verification
The assertions assume that clear_i is a single-cycle synchronous pulse and that cmd_kind_i only matters when cmd_valid_i is high, so a command is judged in the cycle it is presented. They also take iss_ready_i as free to toggle in any cycle, including while no instruction is valid. The directed stimulus changes inputs only on the falling clock edge, holds each command for exactly one cycle, inserts a stall cycle before selected accepts, and waits out the reset synchronizer before issuing any command.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_RUN  = 2'd2
  } cseq_state_e;

  typedef enum logic [1:0] {
    CMD_INSN  = 2'd0,
    CMD_BEGIN = 2'd1,
    CMD_END   = 2'd2,
    CMD_EXEC  = 2'd3
  } cseq_cmd_e;

endpackage

// File: rtl/cseq_rst_sync.sv
module cseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cseq_store.sv
module cseq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 15,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_kind,
  input  logic        iss_ready,
  output logic        wr_en,
  output cseq_state_e state,
  output logic [SW-1:0] size,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] left,
  output logic        err_empty,
  output logic        err_long,
  output logic        err_open
);
  cseq_state_e   state_q, state_d;
  logic [SW-1:0] size_q, size_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] left_q, left_d;
  logic          e_empty_q, e_empty_d;
  logic          e_long_q, e_long_d;
  logic          e_open_q, e_open_d;
  cseq_cmd_e     kind;

  assign kind = cseq_cmd_e'(cmd_kind);

  always_comb begin
    state_d   = state_q;
    size_d    = size_q;
    addr_d    = addr_q;
    left_d    = left_q;
    e_empty_d = e_empty_q;
    e_long_d  = e_long_q;
    e_open_d  = e_open_q;
    wr_en     = 1'b0;
    if (clear) begin
      state_d   = ST_IDLE;
      size_d    = '0;
      addr_d    = '0;
      left_d    = '0;
      e_empty_d = 1'b0;
      e_long_d  = 1'b0;
      e_open_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid && kind == CMD_BEGIN) begin
            state_d = ST_REC;
            size_d  = '0;
            addr_d  = '0;
          end else if (cmd_valid && kind == CMD_EXEC && size_q != '0) begin
            state_d = ST_RUN;
            addr_d  = '0;
            left_d  = AW'(size_q - SW'(1));
          end
        end
        ST_REC: begin
          if (cmd_valid) begin
            unique case (kind)
              CMD_INSN: begin
                if (size_q == SW'(DEPTH)) begin
                  e_long_d = 1'b1;
                end else begin
                  wr_en  = 1'b1;
                  size_d = size_q + SW'(1);
                  addr_d = addr_q + AW'(1);
                end
              end
              CMD_BEGIN: begin
                size_d = '0;
                addr_d = '0;
              end
              CMD_END: begin
                state_d = ST_IDLE;
                addr_d  = '0;
                if (size_q == '0) e_empty_d = 1'b1;
              end
              CMD_EXEC: e_open_d = 1'b1;
              default: ;
            endcase
          end
        end
        ST_RUN: begin
          if (iss_ready) begin
            if (left_q == '0) begin
              state_d = ST_IDLE;
              addr_d  = '0;
            end else begin
              addr_d = addr_q + AW'(1);
              left_d = left_q - AW'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      size_q    <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      e_empty_q <= 1'b0;
      e_long_q  <= 1'b0;
      e_open_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      size_q    <= size_d;
      addr_q    <= addr_d;
      left_q    <= left_d;
      e_empty_q <= e_empty_d;
      e_long_q  <= e_long_d;
      e_open_q  <= e_open_d;
    end
  end

  assign state     = state_q;
  assign size      = size_q;
  assign addr      = addr_q;
  assign left      = left_q;
  assign err_empty = e_empty_q;
  assign err_long  = e_long_q;
  assign err_open  = e_open_q;
endmodule

// File: rtl/cseq_recorder.sv
module cseq_recorder
  import cseq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OPC_W = 5,
  parameter int OPA_W = 4,
  parameter int OPB_W = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DEPTH + 1),
  localparam int IW   = OPC_W + OPA_W + OPB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_kind_i,
  input  logic [OPC_W-1:0] cmd_opc_i,
  input  logic [OPA_W-1:0] cmd_opa_i,
  input  logic [OPB_W-1:0] cmd_opb_i,
  input  logic             iss_ready_i,
  output logic             iss_valid_o,
  output logic [OPC_W-1:0] iss_opc_o,
  output logic [OPA_W-1:0] iss_opa_o,
  output logic [OPB_W-1:0] iss_opb_o,
  output logic [1:0]       state_o,
  output logic [SW-1:0]    size_o,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    left_o,
  output logic             active_o,
  output logic             err_empty_o,
  output logic             err_long_o,
  output logic             err_open_o
);
  logic          rst_sync_n;
  logic          wr_en;
  cseq_state_e   state;
  logic [AW-1:0] addr;
  logic [IW-1:0] rd_word;

  cseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear     (clear_i),
    .cmd_valid (cmd_valid_i),
    .cmd_kind  (cmd_kind_i),
    .iss_ready (iss_ready_i),
    .wr_en     (wr_en),
    .state     (state),
    .size      (size_o),
    .addr      (addr),
    .left      (left_o),
    .err_empty (err_empty_o),
    .err_long  (err_long_o),
    .err_open  (err_open_o)
  );

  cseq_store #(.DEPTH(DEPTH), .WIDTH(IW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data ({cmd_opc_i, cmd_opa_i, cmd_opb_i}),
    .rd_addr (addr),
    .rd_data (rd_word)
  );

  assign iss_valid_o = (state == ST_RUN);
  assign active_o    = (state != ST_IDLE);
  assign state_o     = state;
  assign addr_o      = addr;
  assign iss_opc_o   = rd_word[IW-1 -: OPC_W];
  assign iss_opa_o   = rd_word[OPB_W +: OPA_W];
  assign iss_opb_o   = rd_word[OPB_W-1:0];
endmodule

// File: rtl/cseq_checks.sv
module cseq_checks #(
  parameter int DEPTH = 16,
  parameter int OPC_W = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             iss_ready_i,
  input logic             iss_valid_o,
  input logic [OPC_W-1:0] iss_opc_o,
  input logic [1:0]       state_o,
  input logic [SW-1:0]    size_o,
  input logic [AW-1:0]    left_o,
  input logic             err_empty_o,
  input logic             err_long_o,
  input logic             err_open_o
);
  a_r1_clear_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (state_o == 2'd0 && size_o == '0 && !err_empty_o && !err_long_o && !err_open_o));

  a_r4_size_bound: assert property (@(posedge clk) disable iff (!rst_n)
    size_o <= SW'(DEPTH));

  a_r4_long_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_long_o) |-> $past(size_o) == SW'(DEPTH));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_o && !iss_ready_i && !clear_i) |=>
      (iss_valid_o && $stable(left_o) && $stable(iss_opc_o)));

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_o && iss_ready_i && left_o != '0 && !clear_i) |=>
      (iss_valid_o && left_o == $past(left_o) - 1'b1));

  a_r8_last_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_o && iss_ready_i && left_o == '0) |=> (state_o == 2'd0 && !iss_valid_o));

  a_r9_empty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_empty_o && !clear_i) |=> err_empty_o);

  a_r9_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_long_o && !clear_i) |=> err_long_o);

  a_r9_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_open_o && !clear_i) |=> err_open_o);
endmodule

bind cseq_recorder cseq_checks #(.DEPTH(DEPTH), .OPC_W(OPC_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_i     (clear_i),
  .iss_ready_i (iss_ready_i),
  .iss_valid_o (iss_valid_o),
  .iss_opc_o   (iss_opc_o),
  .state_o     (state_o),
  .size_o      (size_o),
  .left_o      (left_o),
  .err_empty_o (err_empty_o),
  .err_long_o  (err_long_o),
  .err_open_o  (err_open_o)
);

// File: tb/cseq_recorder_tb.sv
module cseq_recorder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clear_i;
  logic       cmd_valid_i;
  logic [1:0] cmd_kind_i;
  logic [4:0] cmd_opc_i;
  logic [3:0] cmd_opa_i;
  logic [5:0] cmd_opb_i;
  logic       iss_ready_i;
  logic       iss_valid_o;
  logic [4:0] iss_opc_o;
  logic [3:0] iss_opa_o;
  logic [5:0] iss_opb_o;
  logic [1:0] state_o;
  logic [4:0] size_o;
  logic [3:0] addr_o;
  logic [3:0] left_o;
  logic       active_o;
  logic       err_empty_o, err_long_o, err_open_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [14:0] exp_q [16];

  always #5 clk = ~clk;

  cseq_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .cmd_valid_i(cmd_valid_i),
    .cmd_kind_i(cmd_kind_i), .cmd_opc_i(cmd_opc_i), .cmd_opa_i(cmd_opa_i),
    .cmd_opb_i(cmd_opb_i), .iss_ready_i(iss_ready_i), .iss_valid_o(iss_valid_o),
    .iss_opc_o(iss_opc_o), .iss_opa_o(iss_opa_o), .iss_opb_o(iss_opb_o),
    .state_o(state_o), .size_o(size_o), .addr_o(addr_o), .left_o(left_o),
    .active_o(active_o), .err_empty_o(err_empty_o), .err_long_o(err_long_o),
    .err_open_o(err_open_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] pat(input int seed, input int i);
    return 15'((seed * 977 + i * 1237 + 91) ^ (i << 9));
  endfunction

  task automatic send(input logic [1:0] kind, input logic [14:0] w);
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_kind_i  = kind;
    {cmd_opc_i, cmd_opa_i, cmd_opb_i} = w;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic chk_status(input string req, input int st, input int sz, input int lf);
    chk({req, " state"}, int'(state_o), st);
    chk({req, " size"}, int'(size_o), sz);
    chk({req, " left"}, int'(left_o), lf);
    chk({req, " active"}, int'(active_o), (st != 0) ? 1 : 0);
  endtask

  task automatic record(input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q[i] = pat(seed, i);
      send(2'd0, exp_q[i]);
    end
  endtask

  task automatic drain(input int n, input int stall_at);
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) begin
        iss_ready_i = 1'b0;
        @(negedge clk);
        chk("R8 stall addr", int'(addr_o), i);
      end
      chk("R7 valid", int'(iss_valid_o), 1);
      chk("R8 word", int'({iss_opc_o, iss_opa_o, iss_opb_o}), int'(exp_q[i]));
      chk("R8 left", int'(left_o), n - 1 - i);
      iss_ready_i = 1'b1;
      @(negedge clk);
      iss_ready_i = 1'b0;
    end
    chk("R8 done valid", int'(iss_valid_o), 0);
    chk_status("R8 done R11", 0, n, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clear_i = 1'b0; cmd_valid_i = 1'b0; cmd_kind_i = 2'd0;
    cmd_opc_i = '0; cmd_opa_i = '0; cmd_opb_i = '0; iss_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_status("R1 reset", 0, 0, 0);
    chk("R1 reset valid", int'(iss_valid_o), 0);
    chk("R1 reset errs", int'({err_empty_o, err_long_o, err_open_o}), 0);
  endtask

  task automatic t_basic();
    send(2'd1, '0);
    chk_status("R2 begin R11", 1, 0, 0);
    chk("R2 begin addr", int'(addr_o), 0);
    record(1, 2);
    chk("R3 size", int'(size_o), 2);
    chk("R3 addr", int'(addr_o), 2);
    send(2'd1, '0);
    chk("R2 restart size", int'(size_o), 0);
    record(2, 3);
    send(2'd2, '0);
    chk_status("R5 end", 0, 3, 0);
    chk("R5 end addr", int'(addr_o), 0);
    chk("R5 no err", int'(err_empty_o), 0);
    send(2'd3, '0);
    chk_status("R7 exec", 2, 3, 2);
    chk("R7 addr", int'(addr_o), 0);
    drain(3, 1);
    send(2'd3, '0);
    drain(3, 99);
  endtask

  task automatic t_ignored();
    send(2'd0, 15'h7fff);
    send(2'd2, '0);
    chk_status("R10 idle cmds", 0, 3, 0);
    send(2'd3, '0);
    send(2'd1, '0);
    send(2'd0, 15'h1234);
    chk_status("R10 run cmds", 2, 3, 2);
    chk("R10 run addr", int'(addr_o), 0);
    drain(3, 99);
  endtask

  task automatic t_empty();
    send(2'd1, '0);
    send(2'd2, '0);
    chk_status("R5 empty end", 0, 0, 0);
    chk("R5 err_empty", int'(err_empty_o), 1);
    send(2'd3, '0);
    chk_status("R10 exec empty", 0, 0, 0);
    chk("R10 exec empty valid", int'(iss_valid_o), 0);
  endtask

  task automatic t_overflow();
    send(2'd1, '0);
    record(3, 16);
    chk("R4 full size", int'(size_o), 16);
    chk("R4 no err yet", int'(err_long_o), 0);
    send(2'd0, ~pat(3, 0));
    chk("R4 err_long", int'(err_long_o), 1);
    chk("R4 size held", int'(size_o), 16);
    send(2'd2, '0);
    send(2'd3, '0);
    chk("R7 left full", int'(left_o), 15);
    drain(16, 7);
  endtask

  task automatic t_open();
    send(2'd1, '0);
    record(4, 1);
    send(2'd3, '0);
    chk("R6 err_open", int'(err_open_o), 1);
    chk_status("R6 still rec", 1, 1, 0);
    send(2'd2, '0);
    chk("R9 empty sticky", int'(err_empty_o), 1);
    chk("R9 long sticky", int'(err_long_o), 1);
    chk("R9 open sticky", int'(err_open_o), 1);
    pulse_clear();
    chk_status("R1 clear", 0, 0, 0);
    chk("R1 clear errs", int'({err_empty_o, err_long_o, err_open_o}), 0);
  endtask

  task automatic t_clear_run();
    send(2'd1, '0);
    record(5, 2);
    send(2'd2, '0);
    send(2'd3, '0);
    chk("R7 running", int'(iss_valid_o), 1);
    pulse_clear();
    chk_status("R1 clear in run", 0, 0, 0);
    chk("R1 clear valid", int'(iss_valid_o), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ignored();
    t_empty();
    t_overflow();
    t_open();
    t_clear_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule